// File: doc/BRIEF.md
# Starvation-Driven Queue Criticality Arbiter

This block decides, cycle by cycle, whether a shared memory command port serves a low-priority read queue or a write queue. In normal operation reads are preferred. A queue that keeps waiting is not left to wait without limit. Each queue has a tracker that measures how long the queue has held pending work without being served. The wait is counted in units of 32 clocks. When the wait passes a programmable limit, the queue turns critical and takes the port for a bounded run of accepted commands. After that run it enters a protected window in which it cannot turn critical again.

The surrounding controller supplies the number of transactions waiting in each queue and a strobe that marks when the offered grant was taken. It also supplies one packed configuration word per queue. The block returns a grant per queue, a critical flag per queue and the number of commands left in the current critical run.

Top module: `qcrit_arbiter`

## Requirements
- R1: A free-running divide-by-32 prescaler produces one tick per 32 clocks, the first at the 32nd rising edge after reset is released. Starvation counting and window counting advance only at ticks. A queue that has been starved since reset with a limit of N turns critical at edge 32*(N+1).
- R2: A starve limit of 0 makes a starved queue critical at the first tick. A run-length setting of 0 acts as 1.
- R3: On entry to the critical state the run output is loaded with the smaller of the effective run length and the queue's pending count. The run output reads 0 whenever the queue is not critical.
- R4: Each accepted grant to a critical queue lowers its run output by one. The acceptance made while the run output is 1 ends the critical state at that edge.
- R5: A critical queue whose pending count is zero leaves the critical state at the next edge and its run output goes to 0.
- R6: After a critical run the queue stays non-critical for its window setting in 32-clock units and keeps counting starvation. At the tick where the window expires it turns critical at once if its starve count has reached the limit.
- R7: A critical queue with pending work receives the grant even when the other, non-critical queue also has work.
- R8: When both queues are critical, the queue that turned critical first keeps the grant until its run ends.
- R9: With neither queue critical, the read queue wins. A grant is only given to a queue with a nonzero pending count, and at most one grant is high.
- R10: The read configuration word carries run length in bits 25:22, starve limit in bits 21:11 and window in bits 10:0. The write word carries starve limit in bits 25:15, run length in bits 14:11 and window in bits 10:0.
- R11: During and right after reset both critical flags and both run outputs are 0.
- R12: The default words 26'h03C0780F (read) and 26'h0007F80F (write) set every field to 15. A write queue starved from reset with the default word turns critical at edge 512 with a run of 15 when at least 15 transactions are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_pending | input | PEND_W | Transactions waiting in the read queue |
| wr_pending | input | PEND_W | Transactions waiting in the write queue |
| cmd_accept | input | 1 | The grant offered this cycle was taken |
| rd_cfg | input | 26 | Read queue configuration word |
| wr_cfg | input | 26 | Write queue configuration word |
| rd_grant | output | 1 | Port offered to the read queue |
| wr_grant | output | 1 | Port offered to the write queue |
| rd_critical | output | 1 | Read queue is in a critical run |
| wr_critical | output | 1 | Write queue is in a critical run |
| rd_run | output | 4 | Commands left in the read queue's critical run |
| wr_run | output | 4 | Commands left in the write queue's critical run |

## Verification
A starve counter or prescaler that is off by one shows up as a critical flag rising one tick early or late. That is 32 cycles away from the expected edge, so the bench compares the exact edge of every rise. A wrong run load or a missed decrement shows up in the run output on the first cycle of the run, or on the cycle after an acceptance. A window that is not enforced lets the write queue turn critical a full tick before the expiry edge. A lost seniority bit hands the port to the wrong critical queue in the first cycle both flags are high.

// File: rtl/qcrit_pkg.sv
// Shared types, field widths and configuration decoding for the
// criticality arbiter. Assumes 26-bit configuration words.
package qcrit_pkg;
    localparam int CFG_W    = 26;
    localparam int STARVE_W = 11;
    localparam int RUN_W    = 4;
    localparam int NQ       = 2;
    localparam int QRD      = 0;
    localparam int QWR      = 1;

    // decoded per-queue settings
    typedef struct packed {
        logic [RUN_W-1:0]    run_len;
        logic [STARVE_W-1:0] max_starve;
        logic [STARVE_W-1:0] min_calm;
    } qcfg_t;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_CRIT   = 2'd1,
        ST_CALM   = 2'd2
    } qstate_e;

    // power-up words: every field equals 15
    localparam logic [CFG_W-1:0] RD_CFG_RESET = 26'h03C0780F;
    localparam logic [CFG_W-1:0] WR_CFG_RESET = 26'h0007F80F;

    // read word: run | starve | window
    function automatic qcfg_t unpack_rd(input logic [CFG_W-1:0] w);
        qcfg_t r;
        r.run_len    = w[25:22];
        r.max_starve = w[21:11];
        r.min_calm   = w[10:0];
        return r;
    endfunction

    // write word: starve | run | window
    function automatic qcfg_t unpack_wr(input logic [CFG_W-1:0] w);
        qcfg_t r;
        r.max_starve = w[25:15];
        r.run_len    = w[14:11];
        r.min_calm   = w[10:0];
        return r;
    endfunction
endpackage

// File: rtl/qcrit_prescaler.sv
// Free-running divider producing a one-cycle tick every 2**DIV_W clocks.
// Assumes the counter restarts from zero on reset; first tick follows
// 2**DIV_W-1 edges after reset release and acts on the next edge.
module qcrit_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [DIV_W-1:0] cnt;

    // free-running count
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign tick = &cnt;

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/qcrit_tracker.sv
// Criticality tracker for one queue: counts starvation in tick units,
// enters a critical run, then holds a protected non-critical window.
// Assumes PEND_W >= RUN_W and accept is already qualified by this
// queue's grant.
module qcrit_tracker
    import qcrit_pkg::*;
#(
    parameter int PEND_W   = 6,
    parameter int STARVE_W = 11,
    parameter int RUN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PEND_W-1:0]   pending,
    input  logic                granted,
    input  logic                accept,
    input  logic [STARVE_W-1:0] max_starve,
    input  logic [STARVE_W-1:0] min_calm,
    input  logic [RUN_W-1:0]    run_len,
    output logic                critical,
    output logic [RUN_W-1:0]    run_left
);
    qstate_e             state;
    logic [STARVE_W-1:0] starve_cnt;
    logic [STARVE_W-1:0] win_cnt;
    logic                starving;
    logic                starve_hit;
    logic [RUN_W-1:0]    run_eff;
    logic [PEND_W-1:0]   run_eff_p;
    logic [RUN_W-1:0]    run_load;

    assign starving   = (pending != '0) && !granted;
    assign starve_hit = tick && starving && (starve_cnt >= max_starve);
    assign run_eff    = (run_len == '0) ? RUN_W'(1) : run_len;
    assign run_eff_p  = PEND_W'(run_eff);
    assign run_load   = (pending < run_eff_p) ? RUN_W'(pending) : run_eff;

    // starvation accumulator, saturating, cleared when served or empty
    always_ff @(posedge clk) begin
        if (!rst_n)                           starve_cnt <= '0;
        else if (!starving)                   starve_cnt <= '0;
        else if (tick && (starve_cnt != '1))  starve_cnt <= starve_cnt + 1'b1;
    end

    // state, run counter and window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_NORMAL;
            run_left <= '0;
            win_cnt  <= '0;
        end else begin
            case (state)
                ST_NORMAL: begin
                    if (starve_hit) begin
                        state    <= ST_CRIT;
                        run_left <= run_load;
                    end
                end
                ST_CRIT: begin
                    if (pending == '0) begin
                        state    <= ST_CALM;
                        run_left <= '0;
                        win_cnt  <= min_calm;
                    end else if (accept) begin
                        if (run_left == RUN_W'(1)) begin
                            state    <= ST_CALM;
                            run_left <= '0;
                            win_cnt  <= min_calm;
                        end else begin
                            run_left <= run_left - 1'b1;
                        end
                    end
                end
                ST_CALM: begin
                    if (tick) begin
                        if (win_cnt == '0) begin
                            if (starve_hit) begin
                                state    <= ST_CRIT;
                                run_left <= run_load;
                            end else begin
                                state <= ST_NORMAL;
                            end
                        end else begin
                            win_cnt <= win_cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    state    <= ST_NORMAL;
                    run_left <= '0;
                end
            endcase
        end
    end

    assign critical = (state == ST_CRIT);

    // R3
    run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(critical) |-> (run_left != '0) && (run_left <= run_eff)
                            && (PEND_W'(run_left) <= pending));
    // R3
    run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !critical |-> (run_left == '0));
    // R4
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (critical && accept && (run_left > RUN_W'(1)) && (pending != '0))
        |=> critical && (run_left == $past(run_left) - 1'b1));
    // R5
    empty_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (critical && (pending == '0)) |=> !critical);
    // R6
    calm_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CALM) && !(tick && (win_cnt == '0))) |=> !critical);
endmodule

// File: rtl/qcrit_select.sv
// Two-way grant selector: critical beats non-critical, the earlier
// critical queue keeps the port, otherwise index 0 (read) wins.
// Assumes exactly two queues; crit flags come from the trackers.
module qcrit_select
    import qcrit_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] crit,
    input  logic [NQ-1:0] pend_nz,
    output logic [NQ-1:0] grant
);
    logic [NQ-1:0] crit_eff;
    logic          senior;   // queue that holds seniority while both critical

    assign crit_eff = crit & pend_nz;

    // seniority: follows a lone critical queue, held while both are critical
    always_ff @(posedge clk) begin
        if (!rst_n)                     senior <= 1'b0;
        else if (crit[0] && !crit[1])   senior <= 1'b0;
        else if (crit[1] && !crit[0])   senior <= 1'b1;
        else if (!crit[0] && !crit[1])  senior <= 1'b0;
    end

    // grant decision
    always_comb begin
        grant = '0;
        if (crit_eff[0] && crit_eff[1])  grant[senior] = 1'b1;
        else if (crit_eff[0])            grant[0] = 1'b1;
        else if (crit_eff[1])            grant[1] = 1'b1;
        else if (pend_nz[0])             grant[0] = 1'b1;
        else if (pend_nz[1])             grant[1] = 1'b1;
    end

    // R9
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9
    grant_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend_nz) == '0);
    // R7
    crit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_eff[1] && !crit_eff[0]) |-> grant[1]);
    // R8
    senior_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_eff[0] && crit_eff[1] && $past(crit[1]) && !$past(crit[0]))
        |-> grant[1]);
endmodule

// File: rtl/qcrit_arbiter.sv
// Top: read/write command-port arbiter with starvation-driven
// criticality. Assumes pending counts and cmd_accept are synchronous
// to clk and cmd_accept refers to the grant shown in the same cycle.
module qcrit_arbiter
    import qcrit_pkg::*;
#(
    parameter int PEND_W = 6,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] rd_pending,
    input  logic [PEND_W-1:0] wr_pending,
    input  logic              cmd_accept,
    input  logic [CFG_W-1:0]  rd_cfg,
    input  logic [CFG_W-1:0]  wr_cfg,
    output logic              rd_grant,
    output logic              wr_grant,
    output logic              rd_critical,
    output logic              wr_critical,
    output logic [RUN_W-1:0]  rd_run,
    output logic [RUN_W-1:0]  wr_run
);
    logic              tick;
    logic [PEND_W-1:0] pend [NQ];
    qcfg_t             cfg  [NQ];
    logic [RUN_W-1:0]  run  [NQ];
    logic [NQ-1:0]     crit;
    logic [NQ-1:0]     grant;
    logic [NQ-1:0]     pend_nz;

    assign pend[QRD] = rd_pending;
    assign pend[QWR] = wr_pending;
    assign cfg[QRD]  = unpack_rd(rd_cfg);
    assign cfg[QWR]  = unpack_wr(wr_cfg);

    qcrit_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign pend_nz[q] = (pend[q] != '0);

        qcrit_tracker #(
            .PEND_W   (PEND_W),
            .STARVE_W (STARVE_W),
            .RUN_W    (RUN_W)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .pending    (pend[q]),
            .granted    (grant[q]),
            .accept     (cmd_accept & grant[q]),
            .max_starve (cfg[q].max_starve),
            .min_calm   (cfg[q].min_calm),
            .run_len    (cfg[q].run_len),
            .critical   (crit[q]),
            .run_left   (run[q])
        );
    end

    qcrit_select u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .crit    (crit),
        .pend_nz (pend_nz),
        .grant   (grant)
    );

    assign rd_grant    = grant[QRD];
    assign wr_grant    = grant[QWR];
    assign rd_critical = crit[QRD];
    assign wr_critical = crit[QWR];
    assign rd_run      = run[QRD];
    assign wr_run      = run[QWR];
endmodule

// File: tb/sim_qcrit_arbiter.sv
// Scoreboard bench: scenario tasks push the expected critical-entry
// events (queue, edge, run); a monitor pops them as rises appear.
module sim_qcrit_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_pending = '0, wr_pending = '0;
    logic        cmd_accept = 1'b0;
    logic [25:0] rd_cfg = '0, wr_cfg = '0;
    logic        rd_grant, wr_grant, rd_critical, wr_critical;
    logic [3:0]  rd_run, wr_run;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    typedef struct { int q; int at; int run; string tag; } ev_t;
    ev_t exp_q[$];
    logic prev_rd = 0, prev_wr = 0;

    qcrit_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .rd_pending(rd_pending), .wr_pending(wr_pending),
        .cmd_accept(cmd_accept), .rd_cfg(rd_cfg), .wr_cfg(wr_cfg),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .rd_critical(rd_critical),
        .wr_critical(wr_critical), .rd_run(rd_run), .wr_run(wr_run)
    );

    always #5 clk = ~clk;

    // edges since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic logic [25:0] mk_rd(int run, int stv, int win);
        return {run[3:0], stv[10:0], win[10:0]};
    endfunction
    function automatic logic [25:0] mk_wr(int stv, int run, int win);
        return {stv[10:0], run[3:0], win[10:0]};
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s at edge %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    task automatic expect_rise(int q, int at, int run, string tag);
        ev_t e;
        e.q = q; e.at = at; e.run = run; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic sync(int n);
        do @(negedge clk); while (cyc != n);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic compare_rise(int q, int run);
        ev_t e;
        if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R1 unexpected rise q%0d at edge %0d: got run %0d expected none", q, cyc, run);
        end else begin
            e = exp_q.pop_front();
            chk({e.tag, " queue"}, q, e.q);
            chk({e.tag, " edge"}, cyc, e.at);
            chk({e.tag, " run"}, run, e.run);
        end
    endtask

    // monitor: detect critical entries and score them
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_critical && !prev_rd) compare_rise(0, rd_run);
            if (wr_critical && !prev_wr) compare_rise(1, wr_run);
        end
        prev_rd <= rst_n ? rd_critical : 1'b0;
        prev_wr <= rst_n ? wr_critical : 1'b0;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // ---- R11 reset state, R9 read preference, R10 write packing, R6 window
        rd_pending = 6'd5; wr_pending = 6'd2; cmd_accept = 1'b1;
        rd_cfg = mk_rd(15, 2047, 15); wr_cfg = mk_wr(2, 3, 3);
        repeat (2) @(posedge clk);
        #2;
        chk("R11 rd_critical in reset", rd_critical, 0);
        chk("R11 wr_critical in reset", wr_critical, 0);
        chk("R11 wr_run in reset", wr_run, 0);
        expect_rise(1, 96, 2, "R1 R3 write starve 2");
        expect_rise(1, 224, 3, "R6 window expiry");
        do_reset();
        sync(1);
        chk("R11 rd_run after reset", rd_run, 0);
        chk("R9 read wins rd_grant", rd_grant, 1);
        chk("R9 read wins wr_grant", wr_grant, 0);
        sync(96);
        chk("R7 critical write granted", wr_grant, 1);
        sync(97);
        chk("R4 run decrement", wr_run, 1);
        sync(98);
        chk("R4 run end", wr_critical, 0);
        chk("R3 run zero when idle", wr_run, 0);
        wr_pending = 6'd6;
        sync(200);
        chk("R6 window blocks entry", wr_critical, 0);
        sync(225);
        chk("R4 rerun decrement", wr_run, 2);

        // ---- R2 zero limits, R7 critical beats read
        rd_pending = 6'd4; wr_pending = 6'd7; cmd_accept = 1'b0;
        rd_cfg = mk_rd(15, 2047, 15); wr_cfg = mk_wr(0, 0, 5);
        expect_rise(1, 32, 1, "R2 zero starve and run");
        do_reset();
        sync(31);
        chk("R2 not before first tick", wr_critical, 0);
        sync(32);
        chk("R7 rd_grant blocked", rd_grant, 0);
        chk("R7 wr_grant", wr_grant, 1);
        sync(33);
        chk("R4 holds without accept", wr_run, 1);
        cmd_accept = 1'b1;
        sync(34);
        chk("R4 single accept ends run", wr_critical, 0);

        // ---- R8 seniority, R10 read packing, R5 empty exit
        rd_pending = 6'd9; wr_pending = 6'd15; cmd_accept = 1'b0;
        rd_cfg = mk_rd(4, 0, 15); wr_cfg = mk_wr(0, 15, 15);
        expect_rise(1, 32, 15, "R3 write full run");
        expect_rise(0, 64, 4, "R10 read fields");
        do_reset();
        sync(65);
        chk("R8 both critical", rd_critical, 1);
        chk("R8 senior write keeps", wr_grant, 1);
        chk("R8 junior read waits", rd_grant, 0);
        cmd_accept = 1'b1;
        sync(80);
        chk("R8 write run done", wr_critical, 0);
        chk("R8 read now granted", rd_grant, 1);
        chk("R3 read run intact", rd_run, 4);
        sync(81);
        chk("R4 read decrement", rd_run, 3);
        rd_pending = 6'd0;
        sync(82);
        chk("R5 empty exit", rd_critical, 0);
        chk("R5 run cleared", rd_run, 0);
        chk("R9 no grant when empty", rd_grant, 0);
        chk("R9 write served", wr_grant, 1);

        // ---- R12 default words
        rd_pending = 6'd3; wr_pending = 6'd20; cmd_accept = 1'b1;
        rd_cfg = 26'h03C0780F; wr_cfg = 26'h0007F80F;
        expect_rise(1, 512, 15, "R12 default words");
        do_reset();
        sync(511);
        chk("R12 not early", wr_critical, 0);
        sync(526);
        chk("R12 run near end", wr_run, 1);
        sync(527);
        chk("R12 run complete", wr_critical, 0);
        chk("R12 read regains", rd_grant, 1);

        @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R1 missing rises: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule